// File: doc/BRIEF.md
# Register-Indexed Gather Engine

This block is a sequencer that sits beside a small register file and carries out an indirect register move over a vector of elements. A start command carries three base register numbers and a vector length. The base numbers are a destination base, an index base and a source base. For each element, the engine reads an offset from the index run. It then reads the source register selected by that offset and writes the value into the destination run. The register file itself lies outside the block. The engine drives two combinational read ports and one write port that commits at the clock edge.

Elements are handled one per cycle in ascending order, through a fixed two-stage pipeline. The first stage fetches the offset and the second stage reads the source and writes the result. An offset that is not below the vector length stops the run with a trap. The trap reports the failing element, and that element is not written. The index read is forwarded from the write port in the same cycle. Because of this, each element sees every write made by the elements before it, exactly as a sequential loop would.

Top module: `gather_engine`

## Requirements
- R1: Element i takes its offset from register (idx_base + i) mod NREG on the index read port.
- R2: Element i writes register (dst_base + i) mod NREG with the content of register (src_base + offset) mod NREG, where offset is taken modulo NREG when forming the address.
- R3: Take the cycle in which start is accepted as cycle 0. Element i is written during cycle i + 2, with wr_en high for that one cycle. Writes come in strictly ascending element order, one per cycle. wr_en is never high while busy is low.
- R4: An element whose offset is greater than or equal to VL (unsigned, full data width) is not written. No element after it is written either.
- R5: A trap at element k raises trap for exactly one cycle, in cycle k + 3. busy is low in that cycle. trap_elem equals k and keeps that value until the next trap. done does not rise for that run.
- R6: A run with no trap raises done for exactly one cycle, in cycle VL + 2. busy is high in cycles 1 through VL + 1 and is low in the done cycle.
- R7: A start with VL equal to zero raises done in cycle 1 and makes no write. busy stays low.
- R8: A start while busy is high is ignored. The running operation completes with its original bases and length.
- R9: An element whose index register was written by the element just before it uses the newly written value as its offset.
- R10: All register numbers wrap modulo NREG when a base plus an element index or offset passes the top of the file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start command, accepted when busy is low |
| dst_base | input | AW | Destination base register number |
| idx_base | input | AW | Index base register number |
| src_base | input | AW | Source base register number |
| vlen | input | LW | Vector length |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle pulse: run finished without trap |
| trap | output | 1 | One-cycle pulse: run stopped on an out-of-range offset |
| trap_elem | output | LW | Element index of the last trap |
| ix_addr | output | AW | Index read port address |
| ix_data | input | DW | Index read port data (combinational) |
| sr_addr | output | AW | Source read port address |
| sr_data | input | DW | Source read port data (combinational) |
| wr_en | output | 1 | Write port enable |
| wr_addr | output | AW | Write port address |
| wr_data | output | DW | Write port data |

## Verification
Several index patterns are used:
- A reversed permutation and random in-range offsets test plain address forming.
- Offsets of exactly VL - 1 and VL, placed at the first and at the last element, pin down the bound comparison and the trap position.
- A destination run laid one register above the index run makes every element depend on the previous write, which only the forwarding path resolves.
- Runs placed near the top of the file test the wrap.
- A second start held during a run, and zero or one length, test command acceptance.

Random runs with offsets drawn slightly wider than VL mix traps with clean runs. The bench compares the whole file against a sequential reference.

// File: rtl/gather_pkg.sv
package gather_pkg;

    // How a run ended, registered for one cycle.
    typedef enum logic [1:0] {
        END_NONE = 2'd0,
        END_DONE = 2'd1,
        END_TRAP = 2'd2
    } end_t;

    // Width of the vector-length and element-index fields for a file of nreg registers.
    function automatic int unsigned len_width(input int unsigned nreg);
        return $clog2(nreg) + 1;
    endfunction

endpackage

// File: rtl/gather_issue.sv
module gather_issue #(
    parameter int unsigned AW = 5,
    parameter int unsigned LW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] dst_in,
    input  logic [AW-1:0] idx_in,
    input  logic [AW-1:0] src_in,
    input  logic [LW-1:0] vl_in,
    input  logic          kill,
    input  logic          fin,
    output logic          busy,
    output logic          zero_go,
    output logic          iss_valid,
    output logic [LW-1:0] iss_elem,
    output logic [AW-1:0] ix_addr,
    output logic [AW-1:0] dst_q,
    output logic [AW-1:0] src_q,
    output logic [LW-1:0] vl_q
);

    typedef struct packed {
        logic [AW-1:0] dst;
        logic [AW-1:0] idx;
        logic [AW-1:0] src;
        logic [LW-1:0] vl;
    } cfg_t;

    cfg_t          cfg_q;
    logic [LW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            cnt   <= '0;
            cfg_q <= '0;
        end else if (!busy) begin
            if (start) begin
                cfg_q.dst <= dst_in;
                cfg_q.idx <= idx_in;
                cfg_q.src <= src_in;
                cfg_q.vl  <= vl_in;
                cnt       <= '0;
                busy      <= (vl_in != '0);
            end
        end else if (kill || fin) begin
            busy <= 1'b0;
        end else if (iss_valid) begin
            cnt <= cnt + LW'(1);
        end
    end

    assign zero_go   = start && !busy && (vl_in == '0);
    assign iss_valid = busy && (cnt < cfg_q.vl);
    assign iss_elem  = cnt;
    assign ix_addr   = cfg_q.idx + AW'(cnt);
    assign dst_q     = cfg_q.dst;
    assign src_q     = cfg_q.src;
    assign vl_q      = cfg_q.vl;

    AST_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        busy && start |=> $stable(cfg_q)); // R8

endmodule

// File: rtl/gather_fwd.sv
module gather_fwd #(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32
) (
    input  logic [AW-1:0] ix_addr,
    input  logic [DW-1:0] ix_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] off
);

    // A write landing this cycle on the register being read as an index
    // has not reached the file yet; take it from the write port.
    always_comb begin
        if (wr_en && (wr_addr == ix_addr)) off = wr_data;
        else                               off = ix_data;
    end

endmodule

// File: rtl/gather_commit.sv
module gather_commit
    import gather_pkg::*;
#(
    parameter int unsigned AW = 5,
    parameter int unsigned DW = 32,
    parameter int unsigned LW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [LW-1:0] iss_elem,
    input  logic [DW-1:0] off_in,
    input  logic          zero_go,
    input  logic [AW-1:0] dst_q,
    input  logic [AW-1:0] src_q,
    input  logic [LW-1:0] vl_q,
    output logic [AW-1:0] sr_addr,
    input  logic [DW-1:0] sr_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          kill,
    output logic          fin,
    output logic          done,
    output logic          trap,
    output logic [LW-1:0] trap_elem
);

    logic          p_valid;
    logic [LW-1:0] p_elem;
    logic [DW-1:0] p_off;
    logic          in_bounds;
    end_t          outcome;

    always_ff @(posedge clk) begin
        if (rst) begin
            p_valid   <= 1'b0;
            p_elem    <= '0;
            p_off     <= '0;
            outcome   <= END_NONE;
            trap_elem <= '0;
        end else begin
            p_valid <= iss_valid && !kill;
            p_elem  <= iss_elem;
            p_off   <= off_in;
            if (kill) begin
                outcome   <= END_TRAP;
                trap_elem <= p_elem;
            end else if (fin || zero_go) begin
                outcome <= END_DONE;
            end else begin
                outcome <= END_NONE;
            end
        end
    end

    assign in_bounds = (p_off < DW'(vl_q));
    assign sr_addr   = src_q + AW'(p_off);
    assign wr_en     = p_valid && in_bounds;
    assign wr_addr   = dst_q + AW'(p_elem);
    assign wr_data   = sr_data;
    assign kill      = p_valid && !in_bounds;
    assign fin       = wr_en && (p_elem == vl_q - LW'(1));
    assign done      = (outcome == END_DONE);
    assign trap      = (outcome == END_TRAP);

    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (rst)
        wr_en && $past(wr_en) |-> wr_addr == $past(wr_addr) + AW'(1)); // R3
    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap |-> !wr_en); // R4

endmodule

// File: rtl/gather_engine.sv
module gather_engine #(
    parameter  int unsigned NREG = 32,
    parameter  int unsigned DW   = 32,
    localparam int unsigned AW   = $clog2(NREG),
    localparam int unsigned LW   = gather_pkg::len_width(NREG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] dst_base,
    input  logic [AW-1:0] idx_base,
    input  logic [AW-1:0] src_base,
    input  logic [LW-1:0] vlen,
    output logic          busy,
    output logic          done,
    output logic          trap,
    output logic [LW-1:0] trap_elem,
    output logic [AW-1:0] ix_addr,
    input  logic [DW-1:0] ix_data,
    output logic [AW-1:0] sr_addr,
    input  logic [DW-1:0] sr_data,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);

    logic          iss_valid;
    logic [LW-1:0] iss_elem;
    logic [LW-1:0] vl_q;
    logic [AW-1:0] dst_q;
    logic [AW-1:0] src_q;
    logic          kill;
    logic          fin;
    logic          zero_go;
    logic [DW-1:0] off_fwd;

    gather_issue #(.AW(AW), .LW(LW)) u_issue (
        .clk(clk), .rst(rst), .start(start),
        .dst_in(dst_base), .idx_in(idx_base), .src_in(src_base), .vl_in(vlen),
        .kill(kill), .fin(fin), .busy(busy), .zero_go(zero_go),
        .iss_valid(iss_valid), .iss_elem(iss_elem), .ix_addr(ix_addr),
        .dst_q(dst_q), .src_q(src_q), .vl_q(vl_q)
    );

    gather_fwd #(.AW(AW), .DW(DW)) u_fwd (
        .ix_addr(ix_addr), .ix_data(ix_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .off(off_fwd)
    );

    gather_commit #(.AW(AW), .DW(DW), .LW(LW)) u_commit (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_elem(iss_elem), .off_in(off_fwd),
        .zero_go(zero_go), .dst_q(dst_q), .src_q(src_q), .vl_q(vl_q),
        .sr_addr(sr_addr), .sr_data(sr_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .kill(kill), .fin(fin), .done(done), .trap(trap), .trap_elem(trap_elem)
    );

    AST_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> busy); // R3
    AST_TRAP_IDLE: assert property (@(posedge clk) disable iff (rst)
        trap |-> !busy && !done); // R5
    AST_ZERO_LEN: assert property (@(posedge clk) disable iff (rst)
        start && !busy && vlen == '0 |=> done && !busy); // R7

endmodule

// File: tb/sim_gather_engine.sv
module sim_gather_engine;

    localparam int NREG = 32;
    localparam int AW   = 5;
    localparam int LW   = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] dst_base = '0, idx_base = '0, src_base = '0;
    logic [LW-1:0] vlen = '0;
    logic          busy, done, trap, wr_en;
    logic [LW-1:0] trap_elem;
    logic [AW-1:0] ix_addr, sr_addr, wr_addr;
    logic [31:0]   ix_data, sr_data, wr_data;

    logic [31:0] mem [NREG];
    logic [31:0] pre [NREG];
    logic        load = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    gather_engine u0 (
        .clk(clk), .rst(rst), .start(start),
        .dst_base(dst_base), .idx_base(idx_base), .src_base(src_base), .vlen(vlen),
        .busy(busy), .done(done), .trap(trap), .trap_elem(trap_elem),
        .ix_addr(ix_addr), .ix_data(ix_data), .sr_addr(sr_addr), .sr_data(sr_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    assign ix_data = mem[ix_addr];
    assign sr_data = mem[sr_addr];

    always @(posedge clk) begin
        if (load) begin
            for (int r = 0; r < NREG; r++) mem[r] <= pre[r];
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic commit_pre();
        @(negedge clk); load = 1'b1;
        @(negedge clk); load = 1'b0;
    endtask

    task automatic fill_random(input int modv);
        for (int r = 0; r < NREG; r++) pre[r] = $urandom % modv;
    endtask

    task automatic run(input int d, input int ix, input int s, input int vl,
                       input bit inject, input string tag);
        logic [31:0] rm [NREG];
        logic [31:0] off;
        int exp_k, exp_w, cyc, nw, bad_order, late_wr, mism;
        commit_pre();
        for (int r = 0; r < NREG; r++) rm[r] = mem[r];
        exp_k = -1;
        exp_w = 0;
        for (int i = 0; i < vl; i++) begin
            off = rm[(ix + i) % NREG];
            if (off >= 32'(vl)) begin exp_k = i; break; end
            rm[(d + i) % NREG] = rm[(s + int'(off % NREG)) % NREG];
            exp_w++;
        end
        @(negedge clk);
        dst_base = AW'(d); idx_base = AW'(ix); src_base = AW'(s); vlen = LW'(vl);
        start = 1'b1;
        @(negedge clk);
        if (inject && vl > 0) begin
            dst_base = AW'(d + 7); idx_base = AW'(ix + 3); src_base = AW'(s + 5);
            vlen = LW'(vl ^ 3);
        end else begin
            start = 1'b0;
        end
        cyc = 1; nw = 0; bad_order = 0;
        forever begin
            if (wr_en) begin
                if (wr_addr != AW'(d + nw)) bad_order++;
                nw++;
            end
            if (done || trap || cyc > 100) break;
            @(negedge clk);
            cyc++;
            start = 1'b0;
        end
        if (exp_k < 0) begin
            check(done == 1'b1 && trap == 1'b0, vl == 0 ? "R7" : "R6", {tag, " done"}, done, 1);
            check(cyc == (vl == 0 ? 1 : vl + 2), vl == 0 ? "R7" : "R6", {tag, " done cycle"},
                  cyc, vl == 0 ? 1 : vl + 2);
        end else begin
            check(trap == 1'b1 && done == 1'b0, "R4", {tag, " trap"}, trap, 1);
            check(cyc == exp_k + 3, "R5", {tag, " trap cycle"}, cyc, exp_k + 3);
            check(int'(trap_elem) == exp_k, "R5", {tag, " trap_elem"}, trap_elem, exp_k);
        end
        check(busy == 1'b0, "R6", {tag, " busy at end"}, busy, 0);
        check(nw == exp_w, "R3", {tag, " write count"}, nw, exp_w);
        check(bad_order == 0, "R3", {tag, " write order"}, bad_order, 0);
        late_wr = 0;
        for (int w = 0; w < 3; w++) begin
            @(negedge clk);
            if (wr_en) late_wr++;
        end
        check(late_wr == 0, "R4", {tag, " writes after end"}, late_wr, 0);
        if (exp_k >= 0)
            check(int'(trap_elem) == exp_k, "R5", {tag, " trap_elem held"}, trap_elem, exp_k);
        mism = 0;
        for (int r = 0; r < NREG; r++) if (mem[r] !== rm[r]) mism++;
        check(mism == 0, "R2", {tag, " file contents R1"}, mism, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        for (int r = 0; r < NREG; r++) pre[r] = 32'(r);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !trap && !wr_en, "R6", "reset state",
              {busy, done, trap, wr_en}, 0);

        // R7: zero length
        fill_random(40);
        run(3, 5, 7, 0, 1'b0, "zero length");
        // single element
        fill_random(40); pre[10] = 0;
        run(20, 10, 2, 1, 1'b0, "one element R1");
        // R1 R2: reversed permutation
        fill_random(1000);
        for (int i = 0; i < 8; i++) pre[i] = 32'(7 - i);
        run(16, 0, 8, 8, 1'b0, "reverse perm");
        // R4: offset VL-1 passes, offset VL traps at last element
        fill_random(1000);
        pre[0] = 3; pre[1] = 3; pre[2] = 3; pre[3] = 4;
        run(16, 0, 8, 4, 1'b0, "trap last");
        // R4: trap at first element
        fill_random(1000);
        pre[0] = 4;
        run(16, 0, 8, 4, 1'b0, "trap first");
        // R9: destination run one above the index run
        fill_random(6);
        run(5, 4, 20, 6, 1'b0, "forward R9");
        // R10: wrap near the top
        fill_random(5);
        run(30, 29, 31, 5, 1'b0, "wrap R10");
        // R8: start held during the run
        fill_random(6);
        run(12, 0, 24, 6, 1'b1, "ignored start R8");
        fill_random(1);
        run(12, 0, 24, 1, 1'b1, "ignored start short R8");
        // full length
        fill_random(32);
        run(0, 0, 0, 32, 1'b0, "full file");

        for (int t = 0; t < 40; t++) begin
            int vl;
            vl = $urandom % 13;
            fill_random(vl + 1 + ($urandom % 3));
            run($urandom % NREG, $urandom % NREG, $urandom % NREG, vl, bit'($urandom % 2),
                "random");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule